// File: doc/BRIEF.md
# Banked Matrix-Vector Multiply Engine

This engine computes the product of a square-ish matrix of signed 32-bit integers with a signed 32-bit vector. By default the matrix is 64 by 64 and the vector and result each have 64 entries. One operation runs in four phases, always in the same order. A start pulse opens the operation. The matrix is then streamed in. The vector follows. All row dot products are computed internally. Finally the result words are streamed out, in row order.

Each input and output stream is a single-word valid/ready channel that can move one word per clock. The matrix is held in sixteen column banks, so the sixteen elements of a row slice can be read together. In the same way, the vector buffer presents sixteen entries at once. Each row is handled as four consecutive slices of sixteen columns. A sixteen-multiplier datapath with a registered adder tree starts one slice per cycle, so a new row begins every four cycles. Products and sums keep only their low 32 bits.

The row results collect in a local buffer indexed by row. The buffer is drained once the last row has left the pipeline. A one-cycle done pulse closes the operation.

Top module: `mvm_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, mat_ready, vec_ready and res_valid are all low.
- R2: A start pulse seen while idle opens the matrix phase. In this phase mat_ready is high and exactly 4096 words are taken. Word n is element (row n/64, column n mod 64). mat_ready stays low at all other times, including while idle with mat_valid high.
- R3: The vector phase follows the 4096th matrix word. vec_ready is high only in this phase, and exactly 64 words are taken. Word j is vector element j.
- R4: Result word i equals the sum over j of A[i][j]*b[j]. Each product keeps the low 32 bits of the signed 64-bit product, and every addition wraps modulo 2^32.
- R5: Result words leave in row order 0 to 63. While res_valid is high and res_ready is low, res_valid stays high and res_data holds its value.
- R6: done is high for exactly one cycle: the cycle after the 64th result word is accepted. busy is low in the cycle after that.
- R7: A start pulse received while busy has no effect. Loads and results proceed unchanged, and no new operation begins after done.
- R8: res_valid first rises 262 clock edges after the edge that accepts the last vector word. This is 256 single-slice issue cycles plus the six-stage row pipeline and the drain turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts one operation when idle |
| busy | output | 1 | High from start until the done cycle inclusive |
| done | output | 1 | One-cycle completion pulse |
| mat_valid | input | 1 | Matrix word present |
| mat_ready | output | 1 | Matrix word taken this cycle when valid |
| mat_data | input | 32 | Matrix word, row-major order |
| vec_valid | input | 1 | Vector word present |
| vec_ready | output | 1 | Vector word taken this cycle when valid |
| vec_data | input | 32 | Vector word, index order |
| res_valid | output | 1 | Result word present |
| res_ready | input | 1 | Consumer takes the result word |
| res_data | output | 32 | Result word, row order |

## Verification
The embedded properties place no requirement on the stream inputs. They assume that a consumer may withhold res_ready for any number of cycles, and that start may arrive in any phase. The accumulation-chain property does rely on the engine's own sequencer issuing the slices of a row on back-to-back cycles. The stimulus reflects these freedoms. It pulses start in the middle of the matrix load and in the middle of the store. Its stall pattern drops res_ready on every third cycle. Its matrices are drawn from identity, hashed, all-maximum and mixed minimum/minus-one patterns, so that wrapping products and wrapping sums are exercised.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LOAD_M,
      PH_LOAD_V,
      PH_ISSUE,
      PH_DRAIN,
      PH_STORE,
      PH_FIN
   } phase_t;
endpackage

// File: rtl/mvm_lane_ram.sv
module mvm_lane_ram #(
   parameter int DW    = 32,
   parameter int LANES = 16,
   parameter int DEPTH = 256,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [AW-1:0]              wr_addr,
   input  logic [LW-1:0]              wr_lane,
   input  logic [DW-1:0]              wr_data,
   input  logic [AW-1:0]              rd_addr,
   output logic [LANES-1:0][DW-1:0]   rd_data
);
   // one bank per lane; each lane writes when selected and reads every cycle
   for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (we && (wr_lane == LW'(g))) mem[wr_addr] <= wr_data;
         rd_q <= mem[rd_addr];
      end
      assign rd_data[g] = rd_q;
   end
endmodule

// File: rtl/mvm_dot_pipe.sv
module mvm_dot_pipe #(
   parameter int DW    = 32,
   parameter int LANES = 16,
   parameter int GROUP = 4,
   parameter int ROW_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     iss_vld,
   input  logic                     iss_first,
   input  logic                     iss_last,
   input  logic [ROW_W-1:0]         iss_row,
   input  logic [LANES-1:0][DW-1:0] a_lanes,
   input  logic [LANES-1:0][DW-1:0] b_lanes,
   output logic                     out_vld,
   output logic [ROW_W-1:0]         out_row,
   output logic [DW-1:0]            out_sum,
   output logic                     empty
);
   localparam int NST  = 4;
   localparam int LAST = NST - 1;
   localparam int NGRP = LANES / GROUP;

   if (LANES % GROUP != 0) begin : g_bad_group
      $error("LANES must be a multiple of GROUP");
   end

   // tag pipeline: [0] bank data, [1] products, [2] group sums, [3] slice sum
   logic [NST-1:0]   vld_q, fst_q, lst_q;
   logic [ROW_W-1:0] row_q [NST];

   logic [LANES-1:0][DW-1:0] prod_q;
   logic [NGRP-1:0][DW-1:0]  grp_d, grp_q;
   logic [DW-1:0]            sum_d, sum_q;
   logic [DW-1:0]            acc_q, acc_base, acc_nxt;
   logic                     out_vld_q;
   logic [ROW_W-1:0]         out_row_q;
   logic [DW-1:0]            out_sum_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= '0;
         out_vld_q <= 1'b0;
      end else begin
         vld_q     <= {vld_q[NST-2:0], iss_vld};
         out_vld_q <= vld_q[LAST] && lst_q[LAST];
      end
   end

   always_ff @(posedge clk) begin
      fst_q    <= {fst_q[NST-2:0], iss_first};
      lst_q    <= {lst_q[NST-2:0], iss_last};
      row_q[0] <= iss_row;
      for (int s = 1; s < NST; s++) row_q[s] <= row_q[s-1];
   end

   // multiplier row: low DW bits of each product
   for (genvar l = 0; l < LANES; l++) begin : g_mul
      always_ff @(posedge clk) prod_q[l] <= a_lanes[l] * b_lanes[l];
   end

   // first tree level group: GROUP products per partial sum
   always_comb begin
      for (int g = 0; g < NGRP; g++) begin
         grp_d[g] = '0;
         for (int k = 0; k < GROUP; k++) grp_d[g] = grp_d[g] + prod_q[g*GROUP + k];
      end
   end

   always_comb begin
      sum_d = '0;
      for (int g = 0; g < NGRP; g++) sum_d = sum_d + grp_q[g];
   end

   always_ff @(posedge clk) begin
      grp_q <= grp_d;
      sum_q <= sum_d;
   end

   assign acc_base = fst_q[LAST] ? '0 : acc_q;
   assign acc_nxt  = acc_base + sum_q;

   always_ff @(posedge clk) begin
      if (vld_q[LAST]) begin
         acc_q     <= acc_nxt;
         out_sum_q <= acc_nxt;
         out_row_q <= row_q[LAST];
      end
   end

   assign out_vld = out_vld_q;
   assign out_row = out_row_q;
   assign out_sum = out_sum_q;
   assign empty   = (vld_q == '0) && !out_vld_q;

   // R4: a continuing slice reaches the accumulator right after its predecessor
   a_r4_acc_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[LAST] && !fst_q[LAST]) |-> $past(vld_q[LAST]));
endmodule

// File: rtl/mvm_seq.sv
module mvm_seq
   import mvm_pkg::*;
#(
   parameter int ROWS  = 64,
   parameter int COLS  = 64,
   parameter int LANES = 16,
   localparam int MWORDS = ROWS * COLS,
   localparam int PASSES = COLS / LANES,
   localparam int MDEPTH = ROWS * PASSES,
   localparam int MAW    = (MDEPTH > 1) ? $clog2(MDEPTH) : 1,
   localparam int VAW    = (PASSES > 1) ? $clog2(PASSES) : 1,
   localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int CW     = $clog2(MWORDS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           mat_valid,
   input  logic           vec_valid,
   input  logic           res_ready,
   input  logic           pipe_empty,
   output logic           busy,
   output logic           done,
   output logic           mat_ready,
   output logic           vec_ready,
   output logic           res_valid,
   output logic           m_we,
   output logic [MAW-1:0] m_waddr,
   output logic           v_we,
   output logic [VAW-1:0] v_waddr,
   output logic [LW-1:0]  wr_lane,
   output logic           iss_vld,
   output logic           iss_first,
   output logic           iss_last,
   output logic [RW-1:0]  iss_row,
   output logic [MAW-1:0] m_raddr,
   output logic [VAW-1:0] v_raddr,
   output logic [RW-1:0]  st_idx
);
   phase_t         ph_q;
   logic [CW-1:0]  ld_cnt;
   logic [MAW-1:0] iss_cnt;
   logic [RW-1:0]  st_q;
   logic [MAW-1:0] pass_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         ld_cnt  <= '0;
         iss_cnt <= '0;
         st_q    <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               ph_q   <= PH_LOAD_M;
               ld_cnt <= '0;
            end
            PH_LOAD_M: if (mat_valid) begin
               if (ld_cnt == CW'(MWORDS - 1)) begin
                  ph_q   <= PH_LOAD_V;
                  ld_cnt <= '0;
               end else ld_cnt <= ld_cnt + 1'b1;
            end
            PH_LOAD_V: if (vec_valid) begin
               if (ld_cnt == CW'(COLS - 1)) begin
                  ph_q    <= PH_ISSUE;
                  iss_cnt <= '0;
               end else ld_cnt <= ld_cnt + 1'b1;
            end
            PH_ISSUE: begin
               if (iss_cnt == MAW'(MDEPTH - 1)) ph_q <= PH_DRAIN;
               else iss_cnt <= iss_cnt + 1'b1;
            end
            PH_DRAIN: if (pipe_empty) begin
               ph_q <= PH_STORE;
               st_q <= '0;
            end
            PH_STORE: if (res_ready) begin
               if (st_q == RW'(ROWS - 1)) ph_q <= PH_FIN;
               else st_q <= st_q + 1'b1;
            end
            PH_FIN: ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy      = (ph_q != PH_IDLE);
   assign done      = (ph_q == PH_FIN);
   assign mat_ready = (ph_q == PH_LOAD_M);
   assign vec_ready = (ph_q == PH_LOAD_V);
   assign res_valid = (ph_q == PH_STORE);

   assign m_we    = mat_ready && mat_valid;
   assign v_we    = vec_ready && vec_valid;
   assign m_waddr = MAW'(ld_cnt / CW'(LANES));
   assign v_waddr = VAW'(ld_cnt / CW'(LANES));
   assign wr_lane = LW'(ld_cnt % CW'(LANES));

   assign pass_w    = iss_cnt % MAW'(PASSES);
   assign iss_vld   = (ph_q == PH_ISSUE);
   assign iss_first = (pass_w == '0);
   assign iss_last  = (pass_w == MAW'(PASSES - 1));
   assign iss_row   = RW'(iss_cnt / MAW'(PASSES));
   assign m_raddr   = iss_cnt;
   assign v_raddr   = VAW'(pass_w);
   assign st_idx    = st_q;

   // R3: vector phase opens only from an accepted matrix word
   a_r3_vec_after_mat: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_ready) |-> $past(mat_ready && mat_valid));
   // R6: done lasts a single cycle
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: done follows an accepted result word
   a_r6_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(res_valid && res_ready));
   // R7: start during an operation does not end it
   a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);
endmodule

// File: rtl/mvm_engine.sv
module mvm_engine #(
   parameter int ROWS  = 64,
   parameter int COLS  = 64,
   parameter int DW    = 32,
   parameter int LANES = 16,
   parameter int GROUP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   input  logic          mat_valid,
   output logic          mat_ready,
   input  logic [DW-1:0] mat_data,
   input  logic          vec_valid,
   output logic          vec_ready,
   input  logic [DW-1:0] vec_data,
   output logic          res_valid,
   input  logic          res_ready,
   output logic [DW-1:0] res_data
);
   localparam int PASSES = COLS / LANES;
   localparam int MDEPTH = ROWS * PASSES;
   localparam int MAW    = (MDEPTH > 1) ? $clog2(MDEPTH) : 1;
   localparam int VAW    = (PASSES > 1) ? $clog2(PASSES) : 1;
   localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int RW     = (ROWS > 1) ? $clog2(ROWS) : 1;

   if (COLS % LANES != 0) begin : g_bad_cols
      $error("COLS must be a multiple of LANES");
   end
   if ((1 << RW) != ROWS) begin : g_bad_rows
      $error("ROWS must be a power of two");
   end

   logic           m_we, v_we, iss_vld, iss_first, iss_last, pipe_empty;
   logic [MAW-1:0] m_waddr, m_raddr;
   logic [VAW-1:0] v_waddr, v_raddr;
   logic [LW-1:0]  wr_lane;
   logic [RW-1:0]  iss_row, st_idx, out_row;
   logic           out_vld;
   logic [DW-1:0]  out_sum;
   logic [LANES-1:0][DW-1:0] a_lanes, b_lanes;
   logic [DW-1:0]  rbuf [ROWS];

   mvm_seq #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mat_valid(mat_valid), .vec_valid(vec_valid), .res_ready(res_ready),
      .pipe_empty(pipe_empty),
      .busy(busy), .done(done), .mat_ready(mat_ready), .vec_ready(vec_ready),
      .res_valid(res_valid),
      .m_we(m_we), .m_waddr(m_waddr), .v_we(v_we), .v_waddr(v_waddr),
      .wr_lane(wr_lane),
      .iss_vld(iss_vld), .iss_first(iss_first), .iss_last(iss_last),
      .iss_row(iss_row), .m_raddr(m_raddr), .v_raddr(v_raddr),
      .st_idx(st_idx)
   );

   mvm_lane_ram #(.DW(DW), .LANES(LANES), .DEPTH(MDEPTH)) mat_ram_i (
      .clk(clk), .we(m_we), .wr_addr(m_waddr), .wr_lane(wr_lane),
      .wr_data(mat_data), .rd_addr(m_raddr), .rd_data(a_lanes)
   );

   mvm_lane_ram #(.DW(DW), .LANES(LANES), .DEPTH(PASSES)) vec_ram_i (
      .clk(clk), .we(v_we), .wr_addr(v_waddr), .wr_lane(wr_lane),
      .wr_data(vec_data), .rd_addr(v_raddr), .rd_data(b_lanes)
   );

   mvm_dot_pipe #(.DW(DW), .LANES(LANES), .GROUP(GROUP), .ROW_W(RW)) pipe_i (
      .clk(clk), .rst_n(rst_n),
      .iss_vld(iss_vld), .iss_first(iss_first), .iss_last(iss_last),
      .iss_row(iss_row), .a_lanes(a_lanes), .b_lanes(b_lanes),
      .out_vld(out_vld), .out_row(out_row), .out_sum(out_sum),
      .empty(pipe_empty)
   );

   always_ff @(posedge clk) begin
      if (out_vld) rbuf[out_row] <= out_sum;
   end

   assign res_data = rbuf[st_idx];

   // R5: an offered result word is held until taken
   a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
endmodule

// File: tb/mvm_engine_tb_top.sv
module mvm_engine_tb_top;
   localparam int N = 64;
   localparam int LAT = 262;
   localparam int NCASE = 5;
   localparam int CASE_KIND  [NCASE] = '{0, 1, 2, 3, 1};
   localparam int CASE_SEED  [NCASE] = '{0, 17, 0, 5, 99};
   localparam int CASE_STALL [NCASE] = '{0, 0, 1, 0, 1};
   localparam int CASE_SPAM  [NCASE] = '{0, 0, 0, 1, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done;
   logic        mat_valid = 1'b0, mat_ready;
   logic [31:0] mat_data = '0;
   logic        vec_valid = 1'b0, vec_ready;
   logic [31:0] vec_data = '0;
   logic        res_valid, res_ready = 1'b0;
   logic [31:0] res_data;

   int errors = 0;
   int checks = 0;
   int amat [N][N];
   int bvec [N];
   int expv [N];

   always #4 clk = ~clk;

   mvm_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .mat_valid(mat_valid), .mat_ready(mat_ready), .mat_data(mat_data),
      .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
      .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int hsh(input int s, input int n);
      logic [31:0] x;
      x = 32'(s) ^ (32'(n) * 32'h9E3779B9);
      x = x ^ (x >> 15);
      x = x * 32'h85EBCA6B;
      x = x ^ (x >> 13);
      return int'(x);
   endfunction

   function automatic int mat_val(input int kind, input int seed, input int r, input int c);
      case (kind)
         0: return (r == c) ? 1 : 0;
         1: return hsh(seed, r * N + c);
         2: return 32'sh7FFFFFFF;
         default: return ((r + c) % 2 == 1) ? int'(32'h80000000) : -1;
      endcase
   endfunction

   function automatic int vec_val(input int kind, input int seed, input int j);
      case (kind)
         0: return j * 1000 - 31000;
         1: return hsh(seed + 1, 5000 + j);
         2: return (j % 2 == 1) ? int'(32'h80000000) : 32'sh7FFFFFFF;
         default: return hsh(seed, 7000 + j);
      endcase
   endfunction

   task automatic run_op(input int kind, input int seed, input int stall, input int spam);
      int acc, lat, k, cyc, stalled;
      logic [31:0] held;
      for (int i = 0; i < N; i++) begin
         bvec[i] = vec_val(kind, seed, i);
         for (int j = 0; j < N; j++) amat[i][j] = mat_val(kind, seed, i, j);
      end
      for (int i = 0; i < N; i++) begin
         acc = 0;
         for (int j = 0; j < N; j++) acc += amat[i][j] * bvec[j];
         expv[i] = acc;
      end
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2: matrix words, row-major
      mat_valid = 1'b1;
      for (int n = 0; n < N * N; n++) begin
         mat_data = amat[n / N][n % N];
         start = (spam != 0) && (n == 100);
         while (!mat_ready) @(negedge clk);
         if (n == 0) chk(vec_ready == 1'b0, "R3 vec_ready low in matrix phase", 32'(vec_ready), 0);
         @(negedge clk);
      end
      mat_valid = 1'b0;
      start = 1'b0;
      // R3: vector words
      vec_valid = 1'b1;
      for (int j = 0; j < N; j++) begin
         vec_data = bvec[j];
         while (!vec_ready) @(negedge clk);
         if (j == 0) chk(mat_ready == 1'b0, "R2 mat_ready low in vector phase", 32'(mat_ready), 0);
         @(negedge clk);
      end
      vec_valid = 1'b0;
      lat = 0;
      while (!res_valid && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == LAT, "R8 latency to first result", 32'(lat), 32'(LAT));
      k = 0;
      cyc = 0;
      stalled = 0;
      held = '0;
      while (k < N && cyc < 400) begin
         res_ready = (stall == 0) || (cyc % 3 != 1);
         start = (spam != 0) && (cyc == 20);
         if (stalled != 0) begin
            chk(res_valid && res_data == held, "R5 held word while stalled", res_data, held);
            stalled = 0;
         end
         if (res_valid && res_ready) begin
            chk(res_data == 32'(expv[k]), $sformatf("R4 R5 row %0d", k), res_data, 32'(expv[k]));
            k++;
         end else if (res_valid) begin
            held = res_data;
            stalled = 1;
         end
         cyc++;
         @(negedge clk);
      end
      res_ready = 1'b0;
      start = 1'b0;
      chk(done == 1'b1, "R6 done after last accept", 32'(done), 1);
      chk(res_valid == 1'b0, "R6 no result after last", 32'(res_valid), 0);
      @(negedge clk);
      chk(done == 1'b0, "R6 done single cycle", 32'(done), 0);
      chk(busy == 1'b0, "R6 busy low after done", 32'(busy), 0);
      if (spam != 0) begin
         repeat (3) begin
            @(negedge clk);
            chk(busy == 1'b0 && mat_ready == 1'b0, "R7 no extra operation", 32'(busy), 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(negedge clk);
      chk(!busy && !done, "R1 busy/done low in reset", {busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
      chk(!mat_ready && !vec_ready, "R1 readies after reset", {mat_ready, vec_ready}, 0);
      chk(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 0);
      // R2: words offered while idle are refused
      mat_valid = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk(mat_ready == 1'b0 && busy == 1'b0, "R2 idle refuses matrix word", 32'(mat_ready), 0);
      end
      mat_valid = 1'b0;
      for (int t = 0; t < NCASE; t++)
         run_op(CASE_KIND[t], CASE_SEED[t], CASE_STALL[t], CASE_SPAM[t]);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule